// File: doc/BRIEF.md
# Vector-by-Scalar Integer Multiply-Accumulate Unit

This block executes one SIMD instruction from the "two vectors and a scalar" integer group: plain multiply, multiply-accumulate and multiply-subtract. A 32-bit instruction word is presented with a one-cycle `start` pulse. The unit first decodes the word. An encoding it cannot execute is reported as undefined, and in that case nothing is written.

For a legal instruction, the unit reads one scalar element from the register file and copies it across every lane of a 32-bit word. It then walks the source vector one 32-bit word per pass. In each pass it multiplies every lane by the scalar and, depending on the operation, adds the product to the old destination lane or takes it away from that lane. The result goes back to the destination register at the same word position.

The register file sits outside the block. It is a bank of 64-bit registers, each made of two 32-bit words. It is reached through one combinational read port and one write port, both addressed by a 5-bit register number and a 1-bit word index. The block is used by an instruction sequencer that waits for `done` and looks at `undef` in that cycle.

Top module: `vsm_top`

## Requirements
- R1: The word is undefined unless bits [31:25]=1111001, bit 23=1, bit 6=1, bit 4=0 and bits [11:8] is one of 0000 (accumulate: old+product), 0100 (subtract: old-product) or 1000 (plain product). An undefined instruction performs no register write.
- R2: Bits [21:20] pick the lane width: 01 gives 16-bit lanes and 10 gives 32-bit lanes. The values 00 and 11 are undefined.
- R3: When bit 24 (vector-length flag) is 1 and either the destination or the first-source register number is odd, the instruction is undefined.
- R4: While `regs16Only` is 1, a destination, source or scalar register number with bit 4 set makes the instruction undefined.
- R5: Each 5-bit register number has its extra bit on top: destination = {bit 22, bits [15:12]}, source = {bit 7, bits [19:16]}, scalar = {bit 5, bits [3:0]}.
- R6: With 16-bit lanes, the scalar is read from register scalar[2:0], word scalar[4]. If scalar[3] is 1 the upper halfword [31:16] is taken, otherwise the lower halfword. That halfword is copied into both halves.
- R7: With 32-bit lanes, the scalar is the word at register scalar[3:0], word scalar[4].
- R8: Pass p (0..P-1) reads source word p and writes destination word p. Word p lives in register base+p[1] at word index p[0]. P is 4 when bit 24 is 1 and 2 when it is 0.
- R9: Every lane product keeps only the low lane-width bits. No carry crosses from one 16-bit lane into the other.
- R10: Accumulate writes old destination lane + product, and subtract writes old destination lane − product, both modulo the lane width. The scalar is read once, before any write.
- R11: `busy` is high from the cycle after `start` is accepted until `done`. `done` is a one-cycle pulse. Counting the edge that accepts `start` as the first, `done` appears after edge 2P+3 for a legal instruction and after edge 2 for an undefined one. `undef` is valid with `done`.
- R12: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept `insn` when idle |
| insn | input | 32 | Instruction word |
| regs16Only | input | 1 | Only registers 0..15 exist |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Instruction was undefined (valid with `done`) |
| rdReg | output | 5 | Read register number |
| rdWord | output | 1 | Read word index |
| rdData | input | 32 | Combinational read data |
| wrEn | output | 1 | Write strobe |
| wrReg | output | 5 | Write register number |
| wrWord | output | 1 | Write word index |
| wrData | output | 32 | Write data |

## Verification
The assertions assume that `regs16Only` stays constant while an instruction runs. They also assume that `rdData` always reflects the register file, including writes the unit itself made earlier. The bench keeps to both conditions. It changes the flag only between instructions, and its register array is modified only by the unit's write port. It models that port as combinational read with a write on the clock edge. `start` is pulsed only while the unit is idle, apart from the one deliberate case that checks that a second pulse is ignored.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 5;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_SCALAR, ST_READN, ST_WRITE, ST_FIN
  } vsmState_t;

  typedef enum logic [1:0] {
    OP_MUL, OP_MAC, OP_MLS
  } vsmOp_t;

  typedef struct packed {
    logic   takeScalar;
    logic   takeVn;
    logic   halfLanes;
    logic   upperHalf;
    vsmOp_t op;
  } vsmStrobe_t;
endpackage

// File: rtl/vsm_ctrl.sv
module vsm_ctrl
  import vsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic              regs16Only,
  output logic              busy,
  output logic              done,
  output logic              undef,
  output logic [REG_AW-1:0] rdReg,
  output logic              rdWord,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrReg,
  output logic              wrWord,
  output vsmStrobe_t        strobe
);
  vsmState_t state;
  logic [31:0] insnQ;
  logic [1:0]  passIdx;
  logic        undefQ;

  // field extraction
  logic              qBit;
  logic [1:0]        sizeF;
  logic [3:0]        opcF;
  logic [REG_AW-1:0] vdNum, vnNum, vmNum;
  logic              fixedOk, opcOk, sizeOk, alignOk, bankOk, isBad;
  logic [1:0]        lastIdx;
  logic [REG_AW-1:0] passOff;

  assign qBit  = insnQ[24];
  assign sizeF = insnQ[21:20];
  assign opcF  = insnQ[11:8];
  assign vdNum = {insnQ[22], insnQ[15:12]};
  assign vnNum = {insnQ[7],  insnQ[19:16]};
  assign vmNum = {insnQ[5],  insnQ[3:0]};

  assign fixedOk = (insnQ[31:25] == 7'b1111001) && insnQ[23] && insnQ[6] && !insnQ[4];
  assign opcOk   = (opcF == 4'b0000) || (opcF == 4'b0100) || (opcF == 4'b1000);
  assign sizeOk  = (sizeF == 2'b01) || (sizeF == 2'b10);
  assign alignOk = !(qBit && (vdNum[0] || vnNum[0]));
  assign bankOk  = !(regs16Only && (vdNum[4] || vnNum[4] || vmNum[4]));
  assign isBad   = !(fixedOk && opcOk && sizeOk && alignOk && bankOk);

  assign lastIdx = qBit ? 2'd3 : 2'd1;
  assign passOff = {{(REG_AW-1){1'b0}}, passIdx[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      insnQ   <= '0;
      passIdx <= '0;
      undefQ  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          insnQ <= insn;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          undefQ  <= isBad;
          passIdx <= '0;
          state   <= isBad ? ST_FIN : ST_SCALAR;
        end
        ST_SCALAR: state <= ST_READN;
        ST_READN:  state <= ST_WRITE;
        ST_WRITE: begin
          if (passIdx == lastIdx) state <= ST_FIN;
          else begin
            passIdx <= passIdx + 2'd1;
            state   <= ST_READN;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_FIN);
  assign undef = (state == ST_FIN) && undefQ;

  always_comb begin
    rdReg  = '0;
    rdWord = 1'b0;
    unique case (state)
      ST_SCALAR: begin
        rdReg  = (sizeF == 2'b01) ? {2'b00, vmNum[2:0]} : {1'b0, vmNum[3:0]};
        rdWord = vmNum[4];
      end
      ST_READN: begin
        rdReg  = vnNum + passOff;
        rdWord = passIdx[0];
      end
      ST_WRITE: begin
        rdReg  = vdNum + passOff;
        rdWord = passIdx[0];
      end
      default: ;
    endcase
  end

  assign wrEn   = (state == ST_WRITE);
  assign wrReg  = vdNum + passOff;
  assign wrWord = passIdx[0];

  always_comb begin
    strobe.takeScalar = (state == ST_SCALAR);
    strobe.takeVn     = (state == ST_READN);
    strobe.halfLanes  = (sizeF == 2'b01);
    strobe.upperHalf  = vmNum[3];
    unique case (opcF)
      4'b0000: strobe.op = OP_MAC;
      4'b0100: strobe.op = OP_MLS;
      default: strobe.op = OP_MUL;
    endcase
  end
endmodule

// File: rtl/vsm_datapath.sv
module vsm_datapath
  import vsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  vsmStrobe_t        strobe,
  input  logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] wrData
);
  localparam int LANES = WORD_W / HALF_W;

  logic [WORD_W-1:0] scalarQ, vnQ;
  logic [HALF_W-1:0] pickHalf;
  logic [WORD_W-1:0] halfRes, fullRes, fullProd;

  assign pickHalf = strobe.upperHalf ? rdData[HALF_W +: HALF_W] : rdData[0 +: HALF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalarQ <= '0;
      vnQ     <= '0;
    end else begin
      if (strobe.takeScalar)
        scalarQ <= strobe.halfLanes ? {LANES{pickHalf}} : rdData;
      if (strobe.takeVn)
        vnQ <= rdData;
    end
  end

  // per-lane 16-bit arithmetic, old destination arrives on rdData
  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [HALF_W-1:0] nH, sH, dH, pH, rH;
    assign nH = vnQ[HALF_W*i +: HALF_W];
    assign sH = scalarQ[HALF_W*i +: HALF_W];
    assign dH = rdData[HALF_W*i +: HALF_W];
    assign pH = nH * sH;
    always_comb begin
      unique case (strobe.op)
        OP_MAC:  rH = dH + pH;
        OP_MLS:  rH = dH - pH;
        default: rH = pH;
      endcase
    end
    assign halfRes[HALF_W*i +: HALF_W] = rH;
  end

  assign fullProd = vnQ * scalarQ;
  always_comb begin
    unique case (strobe.op)
      OP_MAC:  fullRes = rdData + fullProd;
      OP_MLS:  fullRes = rdData - fullProd;
      default: fullRes = fullProd;
    endcase
  end

  assign wrData = strobe.halfLanes ? halfRes : fullRes;
endmodule

// File: rtl/vsm_top.sv
module vsm_top
  import vsm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic              regs16Only,
  output logic              busy,
  output logic              done,
  output logic              undef,
  output logic [REG_AW-1:0] rdReg,
  output logic              rdWord,
  input  logic [WORD_W-1:0] rdData,
  output logic              wrEn,
  output logic [REG_AW-1:0] wrReg,
  output logic              wrWord,
  output logic [WORD_W-1:0] wrData
);
  vsmStrobe_t strobe;

  vsm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .regs16Only(regs16Only), .busy(busy), .done(done), .undef(undef),
    .rdReg(rdReg), .rdWord(rdWord), .wrEn(wrEn), .wrReg(wrReg),
    .wrWord(wrWord), .strobe(strobe)
  );

  vsm_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdData(rdData), .wrData(wrData)
  );
endmodule

// File: rtl/vsm_checks.sv
module vsm_checks (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic qBit,
  input logic regs16Only,
  input logic busy,
  input logic done,
  input logic undef,
  input logic wrEn,
  input logic wrRegTop
);
  logic [2:0] wrCount;
  logic       qLatched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrCount  <= '0;
      qLatched <= 1'b0;
    end else if (start && !busy) begin
      wrCount  <= '0;
      qLatched <= qBit;
    end else if (wrEn) begin
      wrCount <= wrCount + 3'd1;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_undef_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && undef) |-> (wrCount == 3'd0));
  assert_pass_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !undef) |-> (wrCount == (qLatched ? 3'd4 : 3'd2)));
  assert_low_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regs16Only) |-> !wrRegTop);
  assert_write_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |-> (busy && !done));
endmodule

bind vsm_top vsm_checks u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .qBit(insn[24]),
  .regs16Only(regs16Only), .busy(busy), .done(done), .undef(undef),
  .wrEn(wrEn), .wrRegTop(wrReg[4])
);

// File: tb/tb_vsm_top.sv
module tb_vsm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] insn = '0;
  logic        regs16Only = 1'b0;
  logic        busy, done, undef, rdWord, wrEn, wrWord;
  logic [4:0]  rdReg, wrReg;
  logic [31:0] rdData, wrData;

  logic [31:0] rf   [0:31][0:1];
  logic [31:0] gold [0:31][0:1];
  logic [37:0] expQ [$];
  int nChecks = 0, nFail = 0, cyc = 0;
  string curTag = "R10";
  bit finished = 0;

  always #5 clk = ~clk;

  vsm_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .regs16Only(regs16Only),
    .busy(busy), .done(done), .undef(undef), .rdReg(rdReg), .rdWord(rdWord),
    .rdData(rdData), .wrEn(wrEn), .wrReg(wrReg), .wrWord(wrWord), .wrData(wrData)
  );

  assign rdData = rf[rdReg][rdWord];
  always @(posedge clk) if (wrEn) rf[wrReg][wrWord] <= wrData;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison of write traffic against the model queue
  always @(negedge clk) begin
    if (rst_n && wrEn) begin
      if (expQ.size() == 0)
        chk(0, curTag, "unexpected write", {26'd0, wrReg, wrWord, wrData}, 64'd0);
      else begin
        logic [37:0] e;
        e = expQ.pop_front();
        chk({wrReg, wrWord, wrData} == e, curTag, "write", {26'd0, wrReg, wrWord, wrData}, {26'd0, e});
      end
    end
  end

  function automatic logic [31:0] mk(input bit q, input logic [1:0] sz, input logic [3:0] opc,
                                     input logic [4:0] vd, input logic [4:0] vn, input logic [4:0] vm);
    return {7'b1111001, q, 1'b1, vd[4], sz, vn[3:0], vd[3:0], opc, vn[4], 1'b1, vm[4], 1'b0, vm[3:0]};
  endfunction

  function automatic logic [15:0] laneOp(input logic [3:0] opc, input logic [15:0] d,
                                         input logic [15:0] n, input logic [15:0] s);
    logic [15:0] p;
    p = n * s;
    if (opc == 4'b0000) return d + p;
    if (opc == 4'b0100) return d - p;
    return p;
  endfunction

  // behavioural reference: fills expQ and updates gold
  task automatic model(input logic [31:0] ins, input bit r16, output bit und, output int passes);
    logic [4:0] vd, vn, vm;
    logic [3:0] opc;
    logic [1:0] sz;
    logic [31:0] sc;
    bit q;
    vd = {ins[22], ins[15:12]}; vn = {ins[7], ins[19:16]}; vm = {ins[5], ins[3:0]};
    opc = ins[11:8]; sz = ins[21:20]; q = ins[24];
    und = 0;
    if (ins[31:25] != 7'b1111001 || !ins[23] || !ins[6] || ins[4]) und = 1;
    if (!(opc == 4'd0 || opc == 4'd4 || opc == 4'd8)) und = 1;
    if (sz == 2'b00 || sz == 2'b11) und = 1;
    if (q && (vd[0] || vn[0])) und = 1;
    if (r16 && (vd[4] || vn[4] || vm[4])) und = 1;
    passes = q ? 4 : 2;
    if (und) return;
    if (sz == 2'b01) begin
      logic [31:0] w;
      w = gold[vm[2:0]][vm[4]];
      sc = vm[3] ? {w[31:16], w[31:16]} : {w[15:0], w[15:0]};
    end else sc = gold[vm[3:0]][vm[4]];
    for (int p = 0; p < passes; p++) begin
      logic [4:0] dr, nr;
      logic [31:0] n, d, r, prod;
      dr = vd + 5'(p / 2); nr = vn + 5'(p / 2);
      n = gold[nr][p % 2]; d = gold[dr][p % 2];
      if (sz == 2'b01) begin
        r[15:0]  = laneOp(opc, d[15:0], n[15:0], sc[15:0]);
        r[31:16] = laneOp(opc, d[31:16], n[31:16], sc[31:16]);
      end else begin
        prod = n * sc;
        r = (opc == 4'd0) ? d + prod : (opc == 4'd4) ? d - prod : prod;
      end
      expQ.push_back({dr, 1'(p % 2), r});
      gold[dr][p % 2] = r;
    end
  endtask

  task automatic runInsn(input logic [31:0] ins, input bit r16, input string tag, input bit midStart);
    bit und; int passes; int cnt; int expLat;
    curTag = tag;
    regs16Only = r16;
    model(ins, r16, und, passes);
    expLat = und ? 2 : 2 * passes + 3;
    @(negedge clk);
    insn = ins; start = 1'b1;
    @(posedge clk); cnt = 1;
    @(negedge clk); start = 1'b0;
    while (!done && cnt < 200) begin
      if (midStart && cnt == 3) begin insn = ~ins; start = 1'b1; end
      else start = 1'b0;
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    start = 1'b0; insn = ins;
    chk(cnt == expLat, "R11", "done latency", 64'(cnt), 64'(expLat));
    chk(undef == und, tag, "undef flag", 64'(undef), 64'(und));
    chk(expQ.size() == 0, tag, "missing writes", 64'(expQ.size()), 64'd0);
    expQ.delete();
    begin
      bit same = 1;
      for (int r = 0; r < 32; r++)
        for (int w = 0; w < 2; w++)
          if (rf[r][w] !== gold[r][w]) same = 0;
      chk(same, tag, "register file contents", 64'(same), 64'd1);
    end
  endtask

  task automatic setWord(input int r, input int w, input logic [31:0] v);
    rf[r][w] = v; gold[r][w] = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "R11", "watchdog expired", 64'(cyc), 64'd150000);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++)
      for (int w = 0; w < 2; w++) setWord(r, w, $urandom());
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !undef && !wrEn, "R11", "reset outputs", {busy, done, undef, wrEn}, 64'd0);
    rst_n = 1'b1;

    runInsn(mk(0, 2'b10, 4'b1000, 5'd2, 5'd4, 5'd7), 0, "R7", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd3, 5'd5, 5'd25), 0, "R7", 0);
    runInsn(mk(0, 2'b01, 4'b0000, 5'd6, 5'd8, 5'd3), 0, "R6", 0);
    runInsn(mk(0, 2'b01, 4'b0100, 5'd9, 5'd10, 5'd29), 0, "R6", 0);
    runInsn(mk(1, 2'b10, 4'b0000, 5'd12, 5'd14, 5'd1), 0, "R8", 0);
    runInsn(mk(1, 2'b01, 4'b0100, 5'd20, 5'd22, 5'd13), 0, "R8", 0);
    runInsn(mk(0, 2'b10, 4'b0100, 5'd30, 5'd17, 5'd19), 0, "R5", 0);
    // lane wrap: 0xFFFF * 2 in both lanes, no carry across
    setWord(1, 0, 32'hFFFF_FFFF); setWord(0, 0, 32'h0002_0002); setWord(1, 1, 32'h8000_FFFF);
    runInsn(mk(0, 2'b01, 4'b1000, 5'd2, 5'd1, 5'd0), 0, "R9", 0);
    // borrow stays in the low lane
    setWord(4, 0, 32'h0005_0000); setWord(5, 0, 32'h0001_0001); setWord(0, 0, 32'h0003_0003);
    runInsn(mk(0, 2'b01, 4'b0100, 5'd4, 5'd5, 5'd0), 0, "R10", 0);
    runInsn(mk(0, 2'b10, 4'b0000, 5'd4, 5'd4, 5'd8), 0, "R10", 0);
    // undefined encodings
    runInsn(mk(0, 2'b10, 4'b0010, 5'd2, 5'd4, 5'd7), 0, "R1", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd2, 5'd4, 5'd7) | 32'h10, 0, "R1", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd2, 5'd4, 5'd7) & ~32'h0080_0000, 0, "R1", 0);
    runInsn(mk(0, 2'b00, 4'b0000, 5'd2, 5'd4, 5'd7), 0, "R2", 0);
    runInsn(mk(0, 2'b11, 4'b0000, 5'd2, 5'd4, 5'd7), 0, "R2", 0);
    runInsn(mk(1, 2'b10, 4'b1000, 5'd3, 5'd4, 5'd7), 0, "R3", 0);
    runInsn(mk(1, 2'b01, 4'b0000, 5'd2, 5'd5, 5'd7), 0, "R3", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd2, 5'd4, 5'd23), 1, "R4", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd18, 5'd4, 5'd7), 1, "R4", 0);
    runInsn(mk(0, 2'b10, 4'b1000, 5'd2, 5'd4, 5'd7), 1, "R4", 0);
    // second start during busy
    runInsn(mk(1, 2'b10, 4'b0000, 5'd6, 5'd10, 5'd11), 0, "R12", 1);
    for (int k = 0; k < 40; k++) begin
      bit q; logic [1:0] sz; logic [3:0] opc; logic [4:0] vd, vn, vm; int sel;
      q = 1'($urandom_range(0, 1));
      sz = $urandom_range(0, 1) ? 2'b01 : 2'b10;
      sel = $urandom_range(0, 2);
      opc = (sel == 0) ? 4'd0 : (sel == 1) ? 4'd4 : 4'd8;
      vd = 5'($urandom_range(0, 31)); vn = 5'($urandom_range(0, 31)); vm = 5'($urandom_range(0, 31));
      if (q) begin vd[0] = 1'b0; vn[0] = 1'b0; if (vd == 5'd30) vd = 5'd28; if (vn == 5'd30) vn = 5'd28; end
      runInsn(mk(q, sz, opc, vd, vn, vm), 0, "R10", 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule